// File: doc/BRIEF.md
# Cache ECC Error Recovery Sequencer

This block sits next to a cache and takes charge when an ECC fault is reported on one line. It chooses a recovery path from where the fault sits, whether it is single or double bit, and whether the line holds dirty data. A dirty line is first pushed out to next-level memory, single-bit faults being corrected on the way. The line is then dropped and fetched again. A clean line, or any line on the instruction side, is only dropped and fetched again. A 3-bit policy input sets three things: whether checking is on at all, whether every fault raises an abort, and whether writes are forced to write-through.

Error reports arrive on a valid/ready channel and are handled one at a time. The report is taken on a clock edge where `err_valid_i` and `err_ready_o` are both high. `err_ready_o` is high only while the sequencer is idle, so a source holding a report must keep it, unchanged, until that edge. The write-back and refill requests are valid/ready outputs. Once raised, a request and its address and strobes stay fixed until the cycle in which the matching ready input is sampled high. The invalidate, abort and event outputs are one-cycle pulses with no handshake.

The policy input is sampled only while the sequencer is idle. A change made during a recovery takes effect once the sequencer is idle again.

Top module: `ecc_recovery_seq`

## Requirements
- R1: After reset `err_ready_o` is 1, and every request, pulse and `evt_addr_o` is 0.
- R2: With policy code 100, checking is off. A report is accepted and ignored: no write-back, invalidate, refill, abort or event follows, and `err_ready_o` stays 1.
- R3: A report on a clean line gives one `inv_o` pulse in the cycle after acceptance. `refill_valid_o` rises in the next cycle, with `refill_addr_o` set to the reported address. No write-back is issued.
- R4: A report on a dirty line with no double-bit fault raises `wb_valid_o` in the cycle after acceptance, with every bit of `wb_strb_o` set. The invalidate pulse and the refill follow once the write-back is taken.
- R5: A double-bit fault in a dirty line whose location code (`err_loc_i`) is not 00 issues no write-back. Code 01 is the tag, code 10 is the dirty-state storage, and code 11 is handled the same way. Only the invalidate and the refill follow.
- R6: A double-bit fault in data (location code 00) on a dirty line still issues a write-back. Its strobes are the inverse of `err_mask_i`, so the damaged bytes are not written.
- R7: Every double-bit fault raises `abort_o`, whatever the policy code.
- R8: Policy codes 000, 001, 010, 011 and 111 abort on every fault. Codes 101 and 110 raise no abort for single-bit faults. The abort is a one-cycle pulse in the cycle after the refill is taken.
- R9: Policy codes 010 and 110 set `wt_force_o`. Under these codes the line's dirty flag is disregarded, so every recovery is an invalidate followed by a refill.
- R10: Reports flagged as instruction side (`iside_i` = 1) never cause a write-back.
- R11: Every single-bit fault that is recovered gives a one-cycle `evt_o` pulse in the cycle after the refill is taken. From that cycle on, `evt_addr_o` holds the fault address until the next corrected fault. Double-bit faults leave both untouched.
- R12: `err_ready_o` is low from the cycle after acceptance until the sequencer returns to idle, one cycle after the abort/event cycle. While a request is valid and not ready, its valid, address and strobes hold.
- R13: `wt_force_o` and the recovery path follow the policy code sampled at acceptance. A change to `mode_i` during a recovery has no effect until the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Recovery policy code |
| err_valid_i | input | 1 | An error report is offered |
| err_ready_o | output | 1 | Sequencer idle; report taken on this edge |
| err_addr_i | input | AW | Line address of the fault |
| err_loc_i | input | 2 | Fault location: 00 data, 01 tag, 10 dirty-state, 11 other |
| err_dbl_i | input | 1 | Fault is double bit (uncorrectable) |
| err_mask_i | input | NB | Bytes holding a double-bit data fault |
| line_dirty_i | input | 1 | Line holds dirty data |
| iside_i | input | 1 | Report comes from the instruction cache |
| wb_valid_o | output | 1 | Write-back request |
| wb_ready_i | input | 1 | Write-back accepted |
| wb_addr_o | output | AW | Write-back line address |
| wb_strb_o | output | NB | Write-back byte strobes |
| inv_o | output | 1 | Invalidate pulse for the line |
| refill_valid_o | output | 1 | Refill request |
| refill_ready_i | input | 1 | Refill completed |
| refill_addr_o | output | AW | Refill line address |
| abort_o | output | 1 | Abort pulse |
| evt_o | output | 1 | Corrected-fault event pulse |
| evt_addr_o | output | AW | Address of the last corrected fault |
| wt_force_o | output | 1 | Forced write-through in effect |

## Verification
The hardest case to reach is a policy change that lands in the middle of a recovery. A second report with a new policy code is offered while the first is still stalled by the write-back or refill ready. The reference model then has to show that the path and the write-through output keep the old code until idle. To get there, the bench issues the next report immediately after each acceptance and throttles both ready inputs pseudo-randomly. This stretches every recovery and makes the pending report and the new code wait through the busy phase. Double-bit data faults on dirty lines are run both with and without forced write-through, so that the partial strobe path and its suppression are each reached.

// File: rtl/ecc_rec_pkg.sv
package ecc_rec_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVICT,
    ST_INVAL,
    ST_REFILL,
    ST_DONE
  } seq_state_t;

  // fault location codes; only DATA permits a write-back on a double fault
  localparam logic [1:0] LOC_DATA  = 2'b00;
  localparam logic [1:0] LOC_TAG   = 2'b01;
  localparam logic [1:0] LOC_DIRTY = 2'b10;

  // policy codes that change behaviour; the rest abort on every fault
  localparam logic [2:0] POL_OFF       = 3'b100;
  localparam logic [2:0] POL_QUIET     = 3'b101;
  localparam logic [2:0] POL_QUIET_WT  = 3'b110;
  localparam logic [2:0] POL_ABORT_WT  = 3'b010;

endpackage

// File: rtl/ecc_rec_policy.sv
module ecc_rec_policy
  import ecc_rec_pkg::*;
(
  input  logic [2:0] mode_i,
  output logic       check_en_o,
  output logic       abort_all_o,
  output logic       force_wt_o
);

  always_comb begin
    check_en_o  = (mode_i != POL_OFF);
    abort_all_o = !(mode_i == POL_QUIET || mode_i == POL_QUIET_WT || mode_i == POL_OFF);
    force_wt_o  = (mode_i == POL_ABORT_WT || mode_i == POL_QUIET_WT);
  end

endmodule

// File: rtl/ecc_rec_route.sv
module ecc_rec_route
  import ecc_rec_pkg::*;
#(
  parameter int NB = 8
) (
  input  logic          abort_all_i,
  input  logic          force_wt_i,
  input  logic [1:0]    loc_i,
  input  logic          dbl_i,
  input  logic [NB-1:0] mask_i,
  input  logic          dirty_i,
  input  logic          iside_i,
  output logic          do_wb_o,
  output logic [NB-1:0] strb_o,
  output logic          abort_o,
  output logic          corrected_o
);

  logic eff_dirty;
  logic loc_is_data;

  always_comb begin
    // instruction side and forced write-through never hold dirty data
    eff_dirty   = dirty_i && !iside_i && !force_wt_i;
    loc_is_data = (loc_i == LOC_DATA);
    do_wb_o     = eff_dirty && (!dbl_i || loc_is_data);
    strb_o      = dbl_i ? ~mask_i : {NB{1'b1}};
    abort_o     = dbl_i || abort_all_i;
    corrected_o = !dbl_i;
  end

endmodule

// File: rtl/ecc_recovery_seq.sv
module ecc_recovery_seq
  import ecc_rec_pkg::*;
#(
  parameter int AW = 32,
  parameter int NB = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    mode_i,
  input  logic          err_valid_i,
  output logic          err_ready_o,
  input  logic [AW-1:0] err_addr_i,
  input  logic [1:0]    err_loc_i,
  input  logic          err_dbl_i,
  input  logic [NB-1:0] err_mask_i,
  input  logic          line_dirty_i,
  input  logic          iside_i,
  output logic          wb_valid_o,
  input  logic          wb_ready_i,
  output logic [AW-1:0] wb_addr_o,
  output logic [NB-1:0] wb_strb_o,
  output logic          inv_o,
  output logic          refill_valid_o,
  input  logic          refill_ready_i,
  output logic [AW-1:0] refill_addr_o,
  output logic          abort_o,
  output logic          evt_o,
  output logic [AW-1:0] evt_addr_o,
  output logic          wt_force_o
);

  seq_state_t    state, state_nx;
  logic [2:0]    mode_q;
  logic [2:0]    eff_mode;
  logic [AW-1:0] addr_q;
  logic [NB-1:0] strb_q;
  logic          abort_q;
  logic          corr_q;
  logic [AW-1:0] evt_addr_q;

  logic          check_en, abort_all, force_wt;
  logic          do_wb, rt_abort, rt_corr;
  logic [NB-1:0] rt_strb;
  logic          take;

  // policy is live only while idle; otherwise the code latched at acceptance
  assign eff_mode = (state == ST_IDLE) ? mode_i : mode_q;

  ecc_rec_policy u_policy (
    .mode_i      (eff_mode),
    .check_en_o  (check_en),
    .abort_all_o (abort_all),
    .force_wt_o  (force_wt)
  );

  ecc_rec_route #(.NB(NB)) u_route (
    .abort_all_i (abort_all),
    .force_wt_i  (force_wt),
    .loc_i       (err_loc_i),
    .dbl_i       (err_dbl_i),
    .mask_i      (err_mask_i),
    .dirty_i     (line_dirty_i),
    .iside_i     (iside_i),
    .do_wb_o     (do_wb),
    .strb_o      (rt_strb),
    .abort_o     (rt_abort),
    .corrected_o (rt_corr)
  );

  assign err_ready_o = (state == ST_IDLE);
  assign take        = err_valid_i && err_ready_o && check_en;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:   if (take) state_nx = do_wb ? ST_EVICT : ST_INVAL;
      ST_EVICT:  if (wb_ready_i) state_nx = ST_INVAL;
      ST_INVAL:  state_nx = ST_REFILL;
      ST_REFILL: if (refill_ready_i) state_nx = ST_DONE;
      ST_DONE:   state_nx = ST_IDLE;
      default:   state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      mode_q     <= '0;
      addr_q     <= '0;
      strb_q     <= '0;
      abort_q    <= 1'b0;
      corr_q     <= 1'b0;
      evt_addr_q <= '0;
    end else begin
      state <= state_nx;
      if (state == ST_IDLE) mode_q <= mode_i;
      if (take) begin
        addr_q  <= err_addr_i;
        strb_q  <= rt_strb;
        abort_q <= rt_abort;
        corr_q  <= rt_corr;
      end
      if (state == ST_REFILL && refill_ready_i && corr_q) evt_addr_q <= addr_q;
    end
  end

  assign wb_valid_o     = (state == ST_EVICT);
  assign wb_addr_o      = addr_q;
  assign wb_strb_o      = strb_q;
  assign inv_o          = (state == ST_INVAL);
  assign refill_valid_o = (state == ST_REFILL);
  assign refill_addr_o  = addr_q;
  assign abort_o        = (state == ST_DONE) && abort_q;
  assign evt_o          = (state == ST_DONE) && corr_q;
  assign evt_addr_o     = evt_addr_q;
  assign wt_force_o     = force_wt;

  // R12
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid_o && !wb_ready_i |=> wb_valid_o && $stable(wb_strb_o) && $stable(wb_addr_o));

  // R12
  refill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refill_valid_o && !refill_ready_i |=> refill_valid_o && $stable(refill_addr_o));

  // R3
  inv_then_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_o |=> refill_valid_o && !inv_o);

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_ready_o |-> !(wb_valid_o || inv_o || refill_valid_o || abort_o || evt_o));

  // R13
  wt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !err_ready_o && $past(!err_ready_o) |-> $stable(wt_force_o));

  // R11
  evt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |=> !evt_o && err_ready_o);

endmodule

// File: tb/ecc_recovery_seq_test.sv
module ecc_recovery_seq_test;
  localparam int AW = 32;
  localparam int NB = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    mode_i = 3'b000;
  logic          err_valid_i = 1'b0;
  logic          err_ready_o;
  logic [AW-1:0] err_addr_i = '0;
  logic [1:0]    err_loc_i = 2'b00;
  logic          err_dbl_i = 1'b0;
  logic [NB-1:0] err_mask_i = '0;
  logic          line_dirty_i = 1'b0;
  logic          iside_i = 1'b0;
  logic          wb_valid_o;
  logic          wb_ready_i = 1'b0;
  logic [AW-1:0] wb_addr_o;
  logic [NB-1:0] wb_strb_o;
  logic          inv_o;
  logic          refill_valid_o;
  logic          refill_ready_i = 1'b0;
  logic [AW-1:0] refill_addr_o;
  logic          abort_o;
  logic          evt_o;
  logic [AW-1:0] evt_addr_o;
  logic          wt_force_o;

  always #10 clk = ~clk;

  ecc_recovery_seq #(.AW(AW), .NB(NB)) uut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
    .err_valid_i(err_valid_i), .err_ready_o(err_ready_o),
    .err_addr_i(err_addr_i), .err_loc_i(err_loc_i), .err_dbl_i(err_dbl_i),
    .err_mask_i(err_mask_i), .line_dirty_i(line_dirty_i), .iside_i(iside_i),
    .wb_valid_o(wb_valid_o), .wb_ready_i(wb_ready_i), .wb_addr_o(wb_addr_o),
    .wb_strb_o(wb_strb_o), .inv_o(inv_o), .refill_valid_o(refill_valid_o),
    .refill_ready_i(refill_ready_i), .refill_addr_o(refill_addr_o),
    .abort_o(abort_o), .evt_o(evt_o), .evt_addr_o(evt_addr_o),
    .wt_force_o(wt_force_o)
  );

  int vectors = 0;
  int miscompares = 0;
  bit throttle = 1'b0;

  // behavioural reference: phase 0 idle, 1 write-back, 2 invalidate, 3 refill, 4 finish
  int            ph;
  logic [2:0]    m_mode;
  logic [AW-1:0] m_addr, m_evtaddr;
  logic [NB-1:0] m_strb;
  bit            m_abort, m_evt;

  function automatic bit quiet_mode(input logic [2:0] m);
    return (m == 3'b101) || (m == 3'b110);
  endfunction
  function automatic bit wt_mode(input logic [2:0] m);
    return (m == 3'b010) || (m == 3'b110);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; m_mode = 3'b000; m_addr = '0; m_evtaddr = '0; m_strb = '0;
      m_abort = 0; m_evt = 0;
    end else begin
      case (ph)
        0: begin
          m_mode = mode_i;
          if (err_valid_i && mode_i != 3'b100) begin
            bit dirty;
            dirty   = line_dirty_i && !iside_i && !wt_mode(mode_i);
            m_addr  = err_addr_i;
            m_abort = err_dbl_i || !quiet_mode(mode_i);
            m_evt   = !err_dbl_i;
            m_strb  = err_dbl_i ? ~err_mask_i : '1;
            if (dirty && !(err_dbl_i && err_loc_i != 2'b00)) ph = 1;
            else ph = 2;
          end
        end
        1: if (wb_ready_i) ph = 2;
        2: ph = 3;
        3: if (refill_ready_i) begin
             ph = 4;
             if (m_evt) m_evtaddr = m_addr;
           end
        default: ph = 0;
      endcase
    end
  end

  task automatic cmp(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    vectors++;
    cmp("R12 err_ready_o", AW'(err_ready_o), AW'(ph == 0));
    cmp("R4 wb_valid_o", AW'(wb_valid_o), AW'(ph == 1));
    if (ph == 1) begin
      cmp("R4 wb_addr_o", wb_addr_o, m_addr);
      cmp("R6 wb_strb_o", AW'(wb_strb_o), AW'(m_strb));
    end
    cmp("R3 inv_o", AW'(inv_o), AW'(ph == 2));
    cmp("R3 refill_valid_o", AW'(refill_valid_o), AW'(ph == 3));
    if (ph == 3) cmp("R3 refill_addr_o", refill_addr_o, m_addr);
    cmp("R8 abort_o", AW'(abort_o), AW'(ph == 4 && m_abort));
    cmp("R11 evt_o", AW'(evt_o), AW'(ph == 4 && m_evt));
    cmp("R11 evt_addr_o", evt_addr_o, m_evtaddr);
    cmp("R9 wt_force_o", AW'(wt_force_o), AW'(wt_mode(ph == 0 ? mode_i : m_mode)));
  end

  // pseudo-random back-pressure on both request channels
  always @(negedge clk) begin
    #2;
    wb_ready_i     = throttle ? ($urandom % 3 == 0) : 1'b1;
    refill_ready_i = throttle ? ($urandom % 2 == 0) : 1'b1;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      miscompares++;
      $display("FAIL R12 watchdog: actual %0d cycles expected fewer", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic issue(input logic [2:0] m, input logic [AW-1:0] a, input logic [1:0] l,
                       input logic d, input logic [NB-1:0] mk, input logic dy, input logic is);
    bit got;
    @(negedge clk); #2;
    mode_i = m; err_addr_i = a; err_loc_i = l; err_dbl_i = d;
    err_mask_i = mk; line_dirty_i = dy; iside_i = is; err_valid_i = 1'b1;
    forever begin
      got = err_ready_o;
      @(negedge clk); #2;
      if (got) break;
    end
    err_valid_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    vectors++;
    if (err_ready_o !== 1'b1 || wb_valid_o || inv_o || refill_valid_o || abort_o || evt_o || evt_addr_o !== '0) begin
      miscompares++;
      $display("FAIL R1 reset state: actual ready=%b expected ready=1 all others 0", err_ready_o);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    issue(3'b000, 32'h0000_1000, 2'b00, 1'b0, 8'h00, 1'b0, 1'b0); // R3, R8 clean with abort
    issue(3'b101, 32'h0000_2040, 2'b00, 1'b0, 8'h00, 1'b0, 1'b0); // R11 quiet event
    issue(3'b101, 32'h0000_3080, 2'b00, 1'b0, 8'h00, 1'b1, 1'b0); // R4 dirty write-back
    issue(3'b101, 32'h0000_40C0, 2'b01, 1'b1, 8'h00, 1'b1, 1'b0); // R5, R7 tag double
    issue(3'b101, 32'h0000_5100, 2'b00, 1'b1, 8'h30, 1'b1, 1'b0); // R6 partial strobes
    issue(3'b100, 32'h0000_6140, 2'b00, 1'b1, 8'hFF, 1'b1, 1'b0); // R2 checking off
    repeat (4) @(negedge clk);
    issue(3'b010, 32'h0000_7180, 2'b00, 1'b0, 8'h00, 1'b1, 1'b0); // R9 forced write-through
    issue(3'b110, 32'h0000_81C0, 2'b00, 1'b1, 8'h0C, 1'b1, 1'b0); // R9, R7
    issue(3'b101, 32'h0000_9200, 2'b00, 1'b0, 8'h00, 1'b1, 1'b1); // R10 instruction side
    issue(3'b011, 32'h0000_A240, 2'b00, 1'b0, 8'h00, 1'b0, 1'b0); // R8 reserved code
    issue(3'b000, 32'h0000_B280, 2'b10, 1'b1, 8'h00, 1'b1, 1'b0); // R5 dirty-state double
    throttle = 1'b1;
    // R13 and R12: new codes arrive while stalled recoveries run
    for (int i = 0; i < 24; i++) begin
      logic [2:0] m;
      m = 3'($urandom % 8);
      issue(m, 32'h0001_0000 + 32'(i * 64), 2'($urandom % 4), 1'($urandom % 2),
            8'($urandom), 1'($urandom % 2), 1'($urandom % 4 == 0));
    end
    throttle = 1'b0;
    repeat (20) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule